// File: doc/BRIEF.md
# Peripheral interrupt latch controller

This block is the interrupt unit of one peripheral with up to eight sources. Each source has a trigger condition, selected per source as a level or an edge and as high/rising or low/falling. Each source also has a hidden latch that records the condition whether or not the source is enabled. Software can see only the latched-status register, which a source can set only while it is enabled. When an enabled source's visible status bit goes from 0 to 1, the block emits a one-cycle `irq_notify` pulse. That pulse stands in for the outgoing interrupt message.

A source that is enabled while its hidden latch is already set reports the stale event at once. A driver avoids this by writing the clear register and then the enable-set register in one two-byte burst. This works because the clear register sits directly below enable-set and the bus address steps by one on every beat. Register access is a plain synchronous byte port. Write beats take effect at the clock edge that ends the beat. Read data is returned combinationally during the beat.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After reset the status and enable registers read 0x00, the type register (bit=1 selects edge) and the polarity register (bit=1 selects high level or rising edge) both read all ones, and `irq_notify` is low.
- R2: A trigger on a disabled source sets only its hidden latch: the status register does not change and no notification is emitted.
- R3: Writing a 1 to a source's bit at enable-set (offset 0x05) while its hidden latch is set makes its status bit read 1 and raises `irq_notify` for exactly the cycle after that write beat.
- R4: Writing a 1 to a bit of the clear register (offset 0x04) clears both the hidden latch and the status bit of that source. A burst of two beats starting at 0x04 therefore clears and then enables, and emits no notification for a trigger that arrived while the source was disabled.
- R5: Enable-set (0x05) and enable-clear (0x06) act only on bits written as 1. Writing 0 bits leaves the enables unchanged. A read of 0x05 returns the current enable bits.
- R6: A source triggers on a high level (type 0, polarity 1), a low level (type 0, polarity 0), a rising edge (type 1, polarity 1) or a falling edge (type 1, polarity 0). The type register is at 0x01, the polarity register at 0x02 and the status register at 0x00.
- R7: A trigger on an enabled source that is present before a clock edge sets its status bit at that edge, and `irq_notify` is high in the following cycle.
- R8: When a clear and a new trigger for the same source fall in the same cycle, the trigger wins: the hidden latch and the status bit remain set.
- R9: `irq_notify` pulses once per 0-to-1 change of any status bit. Further triggers on a source whose status bit is already set produce no pulse.
- R10: Within a burst the address starts at `acc_addr` on the beat flagged `acc_first` and rises by one on every later beat. Addresses above 0x06 read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Raw source condition inputs |
| acc_valid | input | 1 | Bus beat present this cycle |
| acc_first | input | 1 | Beat starts a burst at `acc_addr` |
| acc_write | input | 1 | Beat is a write (1) or read (0) |
| acc_addr | input | ADDR_W | Start address of a burst |
| acc_wdata | input | 8 | Write data byte |
| acc_rdata | output | 8 | Read data byte of the current beat |
| irq_notify | output | 1 | One-cycle notification pulse |

## Verification
Every write beat updates state at the edge that ends the beat. The bench therefore reads the registers back in a later beat, and it checks `irq_notify` at the falling edge right after that clock edge, then again one cycle later for the drop. A source change is driven at a falling edge and is taken at the next rising edge, so its notification shows up one full cycle after the drive. Notification counts are compared only after one more idle cycle, because the counter samples the pulse at the rising edge that ends it. Read data is sampled a moment into the read beat, before the edge that advances the burst address.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

   localparam int DATA_W = 8;

   // Offsets; clear must sit directly below enable-set so one burst clears then enables.
   localparam int OFS_STATUS = 0;
   localparam int OFS_TYPE   = 1;
   localparam int OFS_POL    = 2;
   localparam int OFS_EN_SET = 5;
   localparam int OFS_CLEAR  = OFS_EN_SET - 1;
   localparam int OFS_EN_CLR = OFS_EN_SET + 1;

   typedef struct packed {
      logic st_type;
      logic st_pol;
      logic st_clear;
      logic st_en_set;
      logic st_en_clr;
   } wr_sel_t;

endpackage

// File: rtl/ilc_bus_port.sv
module ilc_bus_port
   import irq_latch_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int N      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_first,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DATA_W-1:0] acc_wdata,
   input  logic [N-1:0]      status,
   input  logic [N-1:0]      enable,
   input  logic [N-1:0]      trig_type,
   input  logic [N-1:0]      trig_pol,
   output wr_sel_t           wsel,
   output logic [N-1:0]      wmask,
   output logic [DATA_W-1:0] acc_rdata
);

   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
   localparam logic [ADDR_W-1:0] A_TYPE   = ADDR_W'(OFS_TYPE);
   localparam logic [ADDR_W-1:0] A_POL    = ADDR_W'(OFS_POL);
   localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(OFS_CLEAR);
   localparam logic [ADDR_W-1:0] A_EN_SET = ADDR_W'(OFS_EN_SET);
   localparam logic [ADDR_W-1:0] A_EN_CLR = ADDR_W'(OFS_EN_CLR);

   logic [ADDR_W-1:0] next_q;
   logic [ADDR_W-1:0] cur_addr;
   logic              wr_beat;

   assign cur_addr = acc_first ? acc_addr : next_q;
   assign wr_beat  = acc_valid & acc_write;
   assign wmask    = acc_wdata[N-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         next_q <= '0;
      else if (acc_valid)
         next_q <= cur_addr + ADDR_W'(1);
   end

   always_comb begin
      wsel.st_type   = wr_beat && (cur_addr == A_TYPE);
      wsel.st_pol    = wr_beat && (cur_addr == A_POL);
      wsel.st_clear  = wr_beat && (cur_addr == A_CLEAR);
      wsel.st_en_set = wr_beat && (cur_addr == A_EN_SET);
      wsel.st_en_clr = wr_beat && (cur_addr == A_EN_CLR);
   end

   always_comb begin
      acc_rdata = '0;
      if (acc_valid && !acc_write) begin
         if (cur_addr == A_STATUS)
            acc_rdata[N-1:0] = status;
         else if (cur_addr == A_TYPE)
            acc_rdata[N-1:0] = trig_type;
         else if (cur_addr == A_POL)
            acc_rdata[N-1:0] = trig_pol;
         else if (cur_addr == A_EN_SET || cur_addr == A_EN_CLR)
            acc_rdata[N-1:0] = enable;
      end
   end

endmodule

// File: rtl/ilc_config.sv
module ilc_config
   import irq_latch_pkg::*;
#(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  wr_sel_t      wsel,
   input  logic [N-1:0] wmask,
   output logic [N-1:0] trig_type,
   output logic [N-1:0] trig_pol
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_type <= '1;
         trig_pol  <= '1;
      end else begin
         if (wsel.st_type) trig_type <= wmask;
         if (wsel.st_pol)  trig_pol  <= wmask;
      end
   end

endmodule

// File: rtl/ilc_trigger.sv
module ilc_trigger #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] src_in,
   input  logic [N-1:0] trig_type,
   input  logic [N-1:0] trig_pol,
   output logic [N-1:0] trig
);

   logic [N-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= src_in;
   end

   for (genvar i = 0; i < N; i++) begin : g_src
      logic rise, fall, lvl;
      assign rise = src_in[i] & ~prev_q[i];
      assign fall = ~src_in[i] & prev_q[i];
      assign lvl  = ~(src_in[i] ^ trig_pol[i]);
      assign trig[i] = trig_type[i] ? (trig_pol[i] ? rise : fall) : lvl;
   end

endmodule

// File: rtl/ilc_latch_core.sv
module ilc_latch_core #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] trig,
   input  logic [N-1:0] clr_mask,
   input  logic [N-1:0] set_mask,
   input  logic [N-1:0] off_mask,
   output logic [N-1:0] hidden,
   output logic [N-1:0] status,
   output logic [N-1:0] enable,
   output logic         notify
);

   logic [N-1:0] en_d, hid_d, stat_d;

   always_comb begin
      en_d   = (enable | set_mask) & ~off_mask;
      hid_d  = (hidden & ~clr_mask) | trig;
      stat_d = (status & ~clr_mask) | (en_d & hid_d);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable <= '0;
         hidden <= '0;
         status <= '0;
         notify <= 1'b0;
      end else begin
         enable <= en_d;
         hidden <= hid_d;
         status <= stat_d;
         notify <= |(stat_d & ~status);
      end
   end

endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
   import irq_latch_pkg::*;
#(
   parameter int NUM_SRC = 8,
   parameter int ADDR_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_in,
   input  logic               acc_valid,
   input  logic               acc_first,
   input  logic               acc_write,
   input  logic [ADDR_W-1:0]  acc_addr,
   input  logic [DATA_W-1:0]  acc_wdata,
   output logic [DATA_W-1:0]  acc_rdata,
   output logic               irq_notify
);

   if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_num_src
      $error("irq_latch_ctrl: NUM_SRC must be 1..8");
   end
   if (ADDR_W < 3) begin : g_bad_addr_w
      $error("irq_latch_ctrl: ADDR_W must reach offset 6");
   end

   wr_sel_t            wsel;
   logic [NUM_SRC-1:0] wmask;
   logic [NUM_SRC-1:0] type_w, pol_w, trig_w;
   logic [NUM_SRC-1:0] hidden_w, status_w, enable_w;
   logic [NUM_SRC-1:0] clr_mask, set_mask, off_mask;

   assign clr_mask = wsel.st_clear  ? wmask : '0;
   assign set_mask = wsel.st_en_set ? wmask : '0;
   assign off_mask = wsel.st_en_clr ? wmask : '0;

   ilc_bus_port #(.ADDR_W(ADDR_W), .N(NUM_SRC)) u_bus (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_valid (acc_valid),
      .acc_first (acc_first),
      .acc_write (acc_write),
      .acc_addr  (acc_addr),
      .acc_wdata (acc_wdata),
      .status    (status_w),
      .enable    (enable_w),
      .trig_type (type_w),
      .trig_pol  (pol_w),
      .wsel      (wsel),
      .wmask     (wmask),
      .acc_rdata (acc_rdata)
   );

   ilc_config #(.N(NUM_SRC)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wsel      (wsel),
      .wmask     (wmask),
      .trig_type (type_w),
      .trig_pol  (pol_w)
   );

   ilc_trigger #(.N(NUM_SRC)) u_trig (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_in    (src_in),
      .trig_type (type_w),
      .trig_pol  (pol_w),
      .trig      (trig_w)
   );

   ilc_latch_core #(.N(NUM_SRC)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .trig     (trig_w),
      .clr_mask (clr_mask),
      .set_mask (set_mask),
      .off_mask (off_mask),
      .hidden   (hidden_w),
      .status   (status_w),
      .enable   (enable_w),
      .notify   (irq_notify)
   );

endmodule

// File: rtl/ilc_checker.sv
module ilc_checker #(
   parameter int N = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic [N-1:0] stat,
   input logic [N-1:0] en,
   input logic [N-1:0] hid,
   input logic [N-1:0] trig,
   input logic [N-1:0] clr_mask,
   input logic         notify
);

   assert_reset_clean_R1: assert property (@(posedge clk)
      !rst_n |=> (stat == '0 && en == '0 && !notify));

   assert_no_rise_when_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat & ~$past(stat) & ~en) == '0));

   assert_clear_empties_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask & ~trig) != '0 |=> ((hid & $past(clr_mask & ~trig)) == '0));

   assert_trigger_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask & trig) != '0 |=> ((hid & $past(clr_mask & trig)) == $past(clr_mask & trig)));

   assert_notify_has_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
      notify |-> (stat != '0));

   assert_steady_status_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stat == $past(stat)) |-> !notify);

endmodule

bind irq_latch_ctrl ilc_checker #(.N(NUM_SRC)) u_ilc_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .stat     (status_w),
   .en       (enable_w),
   .hid      (hidden_w),
   .trig     (trig_w),
   .clr_mask (clr_mask),
   .notify   (irq_notify)
);

// File: tb/test_irq_latch_ctrl.sv
module test_irq_latch_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int N = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [N-1:0] src_in = '0;
   logic       acc_valid = 1'b0, acc_first = 1'b0, acc_write = 1'b0;
   logic [7:0] acc_addr = '0, acc_wdata = '0;
   logic [7:0] acc_rdata;
   logic       irq_notify;

   int n_chk = 0, n_fail = 0, n_notify = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) if (rst_n && irq_notify) n_notify++;

   irq_latch_ctrl #(.NUM_SRC(N), .ADDR_W(8)) i_irq_latch_ctrl (
      .clk(clk), .rst_n(rst_n), .src_in(src_in),
      .acc_valid(acc_valid), .acc_first(acc_first), .acc_write(acc_write),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
      .irq_notify(irq_notify)
   );

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic idle();
      acc_valid = 0; acc_first = 0; acc_write = 0;
   endtask

   task automatic wr(logic [7:0] a, logic [7:0] d);
      acc_valid = 1; acc_first = 1; acc_write = 1; acc_addr = a; acc_wdata = d;
      @(posedge clk); @(negedge clk);
      idle();
   endtask

   task automatic wr2(logic [7:0] a, logic [7:0] d0, logic [7:0] d1);
      acc_valid = 1; acc_first = 1; acc_write = 1; acc_addr = a; acc_wdata = d0;
      @(posedge clk); @(negedge clk);
      acc_first = 0; acc_addr = 8'hEE; acc_wdata = d1;
      @(posedge clk); @(negedge clk);
      idle();
   endtask

   task automatic rd_beat(bit first, logic [7:0] a, output logic [7:0] d);
      acc_valid = 1; acc_first = first; acc_write = 0; acc_addr = first ? a : 8'hEE;
      #1 d = acc_rdata;
      @(posedge clk); @(negedge clk);
      idle();
   endtask

   task automatic rd_chk(string req, logic [7:0] a, logic [7:0] exp);
      logic [7:0] d;
      rd_beat(1'b1, a, d);
      chk(req, d, exp);
   endtask

   task automatic t_reset();
      chk("R1 notify", irq_notify, 0);
      rd_chk("R1 status", 8'h00, 8'h00);
      rd_chk("R1 enable", 8'h05, 8'h00);
      rd_chk("R1 type", 8'h01, 8'hFF);
      rd_chk("R1 polarity", 8'h02, 8'hFF);
   endtask

   task automatic t_disabled_hidden();
      int n0 = n_notify;
      src_in[0] = 1; @(negedge clk);
      chk("R2 notify while disabled", irq_notify, 0);
      src_in[0] = 0; @(negedge clk);
      rd_chk("R2 status unchanged", 8'h00, 8'h00);
      chk("R2 no pulse count", n_notify - n0, 0);
   endtask

   task automatic t_enable_reveals();
      int n0 = n_notify;
      wr(8'h05, 8'h01);
      chk("R3 notify after enable", irq_notify, 1);
      @(negedge clk);
      chk("R3 notify one cycle", irq_notify, 0);
      rd_chk("R3 status revealed", 8'h00, 8'h01);
      chk("R3 pulse count", n_notify - n0, 1);
   endtask

   task automatic t_clear_burst();
      int n0;
      wr(8'h04, 8'h01);
      rd_chk("R4 clear status", 8'h00, 8'h00);
      src_in[1] = 1; @(negedge clk);
      src_in[1] = 0; @(negedge clk);
      n0 = n_notify;
      wr2(8'h04, 8'h02, 8'h02);
      @(negedge clk);
      chk("R4 burst no pulse", n_notify - n0, 0);
      rd_chk("R4 burst status", 8'h00, 8'h00);
      rd_chk("R5 enable readback", 8'h05, 8'h03);
   endtask

   task automatic t_enabled_trigger();
      int n0 = n_notify;
      src_in[1] = 1; @(negedge clk);
      chk("R7 notify on trigger", irq_notify, 1);
      src_in[1] = 0; @(negedge clk);
      chk("R7 notify drops", irq_notify, 0);
      rd_chk("R7 status", 8'h00, 8'h02);
      src_in[1] = 1; @(negedge clk);
      src_in[1] = 0; @(negedge clk);
      chk("R9 no renotify", n_notify - n0, 1);
      src_in[0] = 1; @(negedge clk);
      src_in[0] = 0; @(negedge clk);
      chk("R9 other source notifies", n_notify - n0, 2);
      rd_chk("R9 status", 8'h00, 8'h03);
      wr(8'h04, 8'h03);
      rd_chk("R4 clear two", 8'h00, 8'h00);
   endtask

   task automatic t_enable_regs();
      wr(8'h06, 8'h01);
      rd_chk("R5 enable clear", 8'h05, 8'h02);
      wr(8'h05, 8'h00);
      rd_chk("R5 zero set no effect", 8'h05, 8'h02);
      wr(8'h06, 8'h00);
      rd_chk("R5 zero clear no effect", 8'h05, 8'h02);
   endtask

   task automatic t_types_and_bursts();
      logic [7:0] d;
      int n0;
      wr2(8'h01, 8'hEB, 8'hE7);
      rd_beat(1'b1, 8'h01, d);
      chk("R10 burst read type", d, 8'hEB);
      rd_beat(1'b0, 8'h00, d);
      chk("R10 burst read polarity", d, 8'hE7);
      rd_chk("R10 unmapped", 8'h10, 8'h00);
      rd_chk("R2 low level while disabled", 8'h00, 8'h00);
      wr(8'h05, 8'h1C);
      chk("R6 low level notify on enable", irq_notify, 1);
      rd_chk("R6 low level status", 8'h00, 8'h10);
      src_in[2] = 1; @(negedge clk);
      chk("R6 high level notify", irq_notify, 1);
      @(negedge clk);
      rd_chk("R6 high level status", 8'h00, 8'h14);
      n0 = n_notify;
      wr(8'h04, 8'h14);
      @(negedge clk);
      rd_chk("R8 trigger beats clear", 8'h00, 8'h14);
      chk("R9 no pulse on held status", n_notify - n0, 0);
      src_in[2] = 0; src_in[4] = 1; @(negedge clk);
      wr(8'h04, 8'h14);
      rd_chk("R4 clear after release", 8'h00, 8'h00);
      src_in[3] = 1; @(negedge clk);
      chk("R6 rising ignored on falling type", irq_notify, 0);
      src_in[3] = 0; @(negedge clk);
      chk("R6 falling edge notify", irq_notify, 1);
      rd_chk("R6 falling status", 8'h00, 8'h08);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_disabled_hidden();
      t_enable_reveals();
      t_clear_burst();
      t_enabled_trigger();
      t_enable_regs();
      t_types_and_bursts();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule